// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Host Sequencer

This block is the host side of a serial link to a chain of voltage-output DAC devices. The chain is wired so that each device's serial output feeds the serial input of the next device. On a one-cycle start strobe it takes one 24-bit instruction per device from a parallel request bus. Any device can instead be marked "skip". The block then shifts the whole chain's worth of bits out on SCK/SDI inside a single chip-select/load window. When the load strobe has risen and the minimum high time has passed, it pulses done.

Each device gets a 32-bit frame. The frame is eight zero pad bits followed by the 24-bit word, most significant bit first. The frame for the device farthest from the host goes out first. The frame for the device nearest the host goes out last, so a single rising edge of the load strobe makes every device act at once. Skipped devices receive the no-operation command.

All phase lengths are counted in system-clock cycles and set by parameters. The bits coming back from the end of the chain are captured at each SCK rising edge, so a loopback test can compare them with what was loaded before.

Top module: `dac_chain_seq`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, busy_o is 0 and done_o is 0. Outside a transfer, cs_n_o stays 1 and sck_o stays 0.
- R2: Each device frame is 32 bits sent MSB first: eight 0 bits, then the 24-bit word. The word carries the command in bits 23:20, the address in bits 19:16 and the data in bits 15:0.
- R3: Device k's word is words_i[k*24 +: 24]. The frame of device NUM_DEV-1 is shifted first and the frame of device 0 is shifted last.
- R4: When skip_i[k] is 1, device k's word is 24'hF00000 (command 1111, address and data zero), whatever words_i holds for it.
- R5: A transfer lowers cs_n_o once, gives exactly 32*NUM_DEV SCK rising edges while cs_n_o is low, and then raises cs_n_o once. SCK is never high while cs_n_o is high.
- R6: Every SCK high phase lasts exactly SCK_HI_CYC cycles, and every low phase between two rising edges lasts exactly SCK_LO_CYC cycles.
- R7: SDI changes only in the cycle where SCK falls, or in the cycle where cs_n_o falls. This gives SCK_LO_CYC cycles of setup and SCK_HI_CYC cycles of hold around every rising edge.
- R8: The first SCK rising edge comes LEAD_CYC cycles after cs_n_o falls. cs_n_o rises TAIL_CYC cycles after the last SCK falling edge.
- R9: done_o is a one-cycle pulse, GAP_CYC cycles after cs_n_o rises. busy_o is 1 from the cycle after start_i is taken until the cycle before done_o.
- R10: A start_i pulse while busy_o is 1 is ignored. It causes no second load window, and it does not change the bits of the transfer in progress. The request bus is captured only when start_i is taken.
- R11: rd_data_o holds the 32*NUM_DEV bits sampled from sdo_i at each SCK rising edge, with the first sample in the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a chain transfer |
| words_i | input | NUM_DEV*24 | Per-device 24-bit instruction, device k in slice k |
| skip_i | input | NUM_DEV | Per-device flag: send no-operation instead of the word |
| sdo_i | input | 1 | Serial data returning from the last device of the chain |
| sck_o | output | 1 | Serial clock to all devices |
| sdi_o | output | 1 | Serial data into the first device |
| cs_n_o | output | 1 | Active-low chip select; its rising edge loads all devices |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | NUM_DEV*32 | Bits captured from sdo_i during the last transfer |

## Verification
The embedded properties watch the line discipline on every cycle. They check that SCK stays quiet outside the select window and that each SCK high phase has the exact length. They check that SDI moves only on a shift or a load, and that done is a single pulse with the load strobe high. Frame content, device order, the no-operation substitution, the lead and tail gaps and the loopback capture depend on a whole transfer. The bench's scenarios show these with a model of the device chain: a scoreboard of expected bits, several request mixes, and a start pulse sent in the middle of a transfer.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int WORD_W  = 24;
    localparam int PAD_W   = 8;
    localparam int FRAME_W = PAD_W + WORD_W;

    localparam logic [3:0] CMD_NOP = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [3:0]  addr;
        logic [15:0] data;
    } dac_word_t;

    // Build one device frame: zero pad bits, then the (possibly replaced) word.
    function automatic logic [FRAME_W-1:0] make_frame(input dac_word_t w, input logic skip);
        dac_word_t f;
        f = w;
        if (skip) begin
            f.cmd  = CMD_NOP;
            f.addr = '0;
            f.data = '0;
        end
        return {{PAD_W{1'b0}}, f};
    endfunction

endpackage

// File: rtl/dcs_frame_pack.sv
module dcs_frame_pack
    import dcs_pkg::*;
#(
    parameter int NUM_DEV = 3
) (
    input  logic [NUM_DEV*WORD_W-1:0]  words_i,
    input  logic [NUM_DEV-1:0]         skip_i,
    output logic [NUM_DEV*FRAME_W-1:0] stream_o
);

    // Device k sits in slot k; the top slot leaves the shifter first.
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
        assign stream_o[k*FRAME_W +: FRAME_W] =
            make_frame(dac_word_t'(words_i[k*WORD_W +: WORD_W]), skip_i[k]);
    end

endmodule

// File: rtl/dcs_timing.sv
module dcs_timing
    import dcs_pkg::*;
#(
    parameter int NUM_DEV    = 3,
    parameter int SCK_HI_CYC = 2,
    parameter int SCK_LO_CYC = 2,
    parameter int LEAD_CYC   = 1,
    parameter int TAIL_CYC   = 1,
    parameter int GAP_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic sck_o,
    output logic cs_n_o,
    output logic busy_o,
    output logic done_o,
    output logic load_o,
    output logic shift_o,
    output logic sample_o
);

    localparam int TOT_BITS = NUM_DEV * FRAME_W;
    localparam int BIT_W    = $clog2(TOT_BITS + 1);
    localparam int MAX_AB   = (SCK_HI_CYC > SCK_LO_CYC) ? SCK_HI_CYC : SCK_LO_CYC;
    localparam int MAX_CD   = (LEAD_CYC > TAIL_CYC) ? LEAD_CYC : TAIL_CYC;
    localparam int MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_MAX  = (MAX_ABCD > GAP_CYC) ? MAX_ABCD : GAP_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [BIT_W-1:0] bits_left;
    logic             last_cnt;
    logic             last_bit;

    always_comb begin
        case (state)
            ST_LEAD: lim = CNT_W'(LEAD_CYC - 1);
            ST_HIGH: lim = CNT_W'(SCK_HI_CYC - 1);
            ST_LOW:  lim = CNT_W'(SCK_LO_CYC - 1);
            ST_TAIL: lim = CNT_W'(TAIL_CYC - 1);
            ST_GAP:  lim = CNT_W'(GAP_CYC - 1);
            default: lim = '0;
        endcase
        last_cnt = (cnt == lim);
        last_bit = (bits_left == BIT_W'(1));
    end

    assign busy_o   = (state != ST_IDLE);
    assign load_o   = (state == ST_IDLE) && start_i;
    assign sample_o = ((state == ST_LEAD) || (state == ST_LOW)) && last_cnt;
    assign shift_o  = (state == ST_HIGH) && last_cnt && !last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            sck_o     <= 1'b0;
            cs_n_o    <= 1'b1;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state     <= ST_LEAD;
                        cs_n_o    <= 1'b0;
                        cnt       <= '0;
                        bits_left <= BIT_W'(TOT_BITS);
                    end
                end
                ST_LEAD, ST_LOW: begin
                    if (last_cnt) begin
                        sck_o <= 1'b1;
                        state <= ST_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (last_cnt) begin
                        sck_o <= 1'b0;
                        cnt   <= '0;
                        if (last_bit) begin
                            state <= ST_TAIL;
                        end else begin
                            bits_left <= bits_left - BIT_W'(1);
                            state     <= ST_LOW;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_TAIL: begin
                    if (last_cnt) begin
                        cs_n_o <= 1'b1;
                        state  <= ST_GAP;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (last_cnt) begin
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Independent run-length counter of the SCK high level.
    logic [CNT_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)        hi_run <= '0;
        else if (sck_o) hi_run <= hi_run + CNT_W'(1);
        else            hi_run <= '0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cs_n_o && !sck_o));

    p_sck_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        sck_o |-> !cs_n_o);

    p_hi_width_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sck_o) |-> (hi_run == CNT_W'(SCK_HI_CYC)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_cs_high_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_n_o && !sck_o));

    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !$fell(cs_n_o));

endmodule

// File: rtl/dcs_shifter.sv
module dcs_shifter
    import dcs_pkg::*;
#(
    parameter int NUM_DEV = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_i,
    input  logic                       shift_i,
    input  logic                       sample_i,
    input  logic [NUM_DEV*FRAME_W-1:0] stream_i,
    input  logic                       sdo_i,
    output logic                       sdi_o,
    output logic [NUM_DEV*FRAME_W-1:0] rd_o
);

    localparam int TOT_BITS = NUM_DEV * FRAME_W;

    logic [TOT_BITS-1:0] tx_q;
    logic [TOT_BITS-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst)          tx_q <= '0;
        else if (load_i)  tx_q <= stream_i;
        else if (shift_i) tx_q <= {tx_q[TOT_BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)           rx_q <= '0;
        else if (sample_i) rx_q <= {rx_q[TOT_BITS-2:0], sdo_i};
    end

    assign sdi_o = tx_q[TOT_BITS-1];
    assign rd_o  = rx_q;

    p_sdi_moves_on_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdi_o) |-> $past(load_i || shift_i));

    p_no_shift_while_sample_r7: assert property (@(posedge clk) disable iff (rst)
        !(shift_i && sample_i));

endmodule

// File: rtl/dac_chain_seq.sv
module dac_chain_seq
    import dcs_pkg::*;
#(
    parameter int NUM_DEV    = 3,
    parameter int SCK_HI_CYC = 2,
    parameter int SCK_LO_CYC = 2,
    parameter int LEAD_CYC   = 1,
    parameter int TAIL_CYC   = 1,
    parameter int GAP_CYC    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [NUM_DEV*24-1:0]      words_i,
    input  logic [NUM_DEV-1:0]         skip_i,
    input  logic                       sdo_i,
    output logic                       sck_o,
    output logic                       sdi_o,
    output logic                       cs_n_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [NUM_DEV*32-1:0]      rd_data_o
);

    localparam int TOT_BITS = NUM_DEV * FRAME_W;

    logic [TOT_BITS-1:0] stream;
    logic                load;
    logic                shift;
    logic                sample;

    dcs_frame_pack #(
        .NUM_DEV (NUM_DEV)
    ) u_pack (
        .words_i  (words_i),
        .skip_i   (skip_i),
        .stream_o (stream)
    );

    dcs_timing #(
        .NUM_DEV    (NUM_DEV),
        .SCK_HI_CYC (SCK_HI_CYC),
        .SCK_LO_CYC (SCK_LO_CYC),
        .LEAD_CYC   (LEAD_CYC),
        .TAIL_CYC   (TAIL_CYC),
        .GAP_CYC    (GAP_CYC)
    ) u_timing (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .sck_o    (sck_o),
        .cs_n_o   (cs_n_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .load_o   (load),
        .shift_o  (shift),
        .sample_o (sample)
    );

    dcs_shifter #(
        .NUM_DEV (NUM_DEV)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .shift_i  (shift),
        .sample_i (sample),
        .stream_i (stream),
        .sdo_i    (sdo_i),
        .sdi_o    (sdi_o),
        .rd_o     (rd_data_o)
    );

endmodule

// File: tb/dac_chain_seq_tb_top.sv
module dac_chain_seq_tb_top;

    localparam int N    = 3;
    localparam int HI   = 2;
    localparam int LO   = 3;
    localparam int LEAD = 3;
    localparam int TAIL = 2;
    localparam int GAP  = 4;
    localparam int TOT  = N * 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N*24-1:0] words = '0;
    logic [N-1:0] skip = '0;
    logic sdo = 1'b0;
    logic sck, sdi, cs_n, busy, done;
    logic [TOT-1:0] rd;

    always #4 clk = ~clk;

    dac_chain_seq #(
        .NUM_DEV(N), .SCK_HI_CYC(HI), .SCK_LO_CYC(LO),
        .LEAD_CYC(LEAD), .TAIL_CYC(TAIL), .GAP_CYC(GAP)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .words_i(words), .skip_i(skip),
        .sdo_i(sdo), .sck_o(sck), .sdi_o(sdi), .cs_n_o(cs_n), .busy_o(busy),
        .done_o(done), .rd_data_o(rd)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_q[$];
    logic [TOT-1:0] chain = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected stream built from the requirements (R2, R3, R4).
    function automatic logic [TOT-1:0] exp_stream(input logic [N*24-1:0] w, input logic [N-1:0] s);
        logic [TOT-1:0] v;
        logic [23:0] wd;
        v = '0;
        for (int d = N - 1; d >= 0; d--) begin
            wd = s[d] ? 24'hF00000 : w[d*24 +: 24];
            v = (v << 32) | TOT'({8'h00, wd});
        end
        return v;
    endfunction

    // Monitor: samples away from the active edge, models the device chain.
    int cyc = 0, t_csfall = 0, t_csrise = 0, t_rise = 0, t_fall = 0;
    int n_rises = 0, n_csfall = 0, n_done = 0;
    logic p_sck = 1'b0, p_cs = 1'b1, p_sdi = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            p_sck = sck; p_cs = cs_n; p_sdi = sdi;
        end else begin
            cyc++;
            if (!cs_n && p_cs) begin
                n_csfall++;
                t_csfall = cyc;
                n_rises = 0;
            end
            if (sdi !== p_sdi)
                check((!sck && p_sck) || (!cs_n && p_cs), "R7", "sdi changed off a fall", 1, 0);
            if (sck && !p_sck) begin
                if (n_rises == 0) check(cyc - t_csfall == LEAD, "R8", "lead cycles", cyc - t_csfall, LEAD);
                else              check(cyc - t_fall == LO, "R6", "low phase", cyc - t_fall, LO);
                n_rises++;
                if (exp_q.size() == 0) check(0, "R5", "extra sck rise", n_rises, TOT);
                else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(sdi == e, "R2", "scoreboard bit", sdi, e);
                end
                chain = {chain[TOT-2:0], sdi};
                t_rise = cyc;
            end
            if (!sck && p_sck) begin
                check(cyc - t_rise == HI, "R6", "high phase", cyc - t_rise, HI);
                sdo = chain[TOT-1];
                t_fall = cyc;
            end
            if (sck) check(!cs_n, "R5", "sck high outside window", cs_n, 0);
            if (cs_n && !p_cs) begin
                check(cyc - t_fall == TAIL, "R8", "tail cycles", cyc - t_fall, TAIL);
                check(n_rises == TOT, "R5", "rising edges per window", n_rises, TOT);
                t_csrise = cyc;
            end
            if (done) begin
                n_done++;
                check(cyc - t_csrise == GAP, "R9", "done gap", cyc - t_csrise, GAP);
                check(cs_n && !busy, "R9", "done with cs high, not busy", {cs_n, busy}, 2'b10);
            end
            p_sck = sck; p_cs = cs_n; p_sdi = sdi;
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: pushes the expected bits, then issues start.
    task automatic run_xfer(input logic [N*24-1:0] w, input logic [N-1:0] s,
                            input logic [TOT-1:0] preload);
        logic [TOT-1:0] v;
        v = exp_stream(w, s);
        for (int i = TOT - 1; i >= 0; i--) exp_q.push_back(v[i]);
        chain = preload;
        sdo = preload[TOT-1];
        words = w;
        skip = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", busy, 1);
    endtask

    initial begin
        logic [TOT-1:0] p0, sa, sb;
        int cf0, dn0;
        repeat (3) @(negedge clk);
        check(cs_n == 1 && sck == 0 && busy == 0 && done == 0, "R1", "outputs in reset",
              {cs_n, sck, busy, done}, 4'b1000);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_n == 1 && sck == 0 && busy == 0 && done == 0, "R1", "idle after reset",
              {cs_n, sck, busy, done}, 4'b1000);

        // Plain transfer, loopback of a known preload.
        p0 = {32'hDEADBEEF, 32'h0123ABCD, 32'h5A5AA5A5};
        run_xfer({24'h3A1234, 24'h2B8001, 24'h30FFFF}, 3'b000, p0);
        wait_done();
        check(rd == p0, "R11", "captured preload", rd, p0);
        sa = exp_stream({24'h3A1234, 24'h2B8001, 24'h30FFFF}, 3'b000);
        check(chain == sa, "R2", "chain contents", chain, sa);
        check(chain[TOT-1 -: 32] == 32'h003A1234, "R3", "farthest device frame", chain[TOT-1 -: 32], 32'h003A1234);
        check(chain[31:0] == 32'h0030FFFF, "R3", "nearest device frame", chain[31:0], 32'h0030FFFF);
        check(exp_q.size() == 0, "R5", "all bits sent", exp_q.size(), 0);

        // Middle device skipped; loopback returns previous stream.
        run_xfer({24'h112233, 24'h445566, 24'h778899}, 3'b010, sa);
        wait_done();
        check(rd == sa, "R11", "captured previous stream", rd, sa);
        check(chain[63:32] == 32'h00F00000, "R4", "skipped device frame", chain[63:32], 32'h00F00000);
        check(chain[TOT-1 -: 32] == 32'h00112233, "R3", "device 2 frame", chain[TOT-1 -: 32], 32'h00112233);
        sb = chain;

        // Start pulse while busy is ignored, bus change mid-transfer too.
        cf0 = n_csfall; dn0 = n_done;
        run_xfer({24'h4C0001, 24'h4C0002, 24'h4C0003}, 3'b000, sb);
        repeat (40) @(negedge clk);
        words = {24'hEEEEEE, 24'hDDDDDD, 24'hCCCCCC};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (GAP + 4) @(negedge clk);
        check(n_csfall - cf0 == 1, "R10", "single load window", n_csfall - cf0, 1);
        check(n_done - dn0 == 1, "R10", "single done", n_done - dn0, 1);
        check(chain == exp_stream({24'h4C0001, 24'h4C0002, 24'h4C0003}, 3'b000), "R10", "stream unaffected",
              chain, exp_stream({24'h4C0001, 24'h4C0002, 24'h4C0003}, 3'b000));
        check(rd == sb, "R11", "capture in ignored-start run", rd, sb);

        // All devices skipped.
        run_xfer({24'h9ABCDE, 24'h876543, 24'h13579B}, 3'b111, '0);
        wait_done();
        for (int d = 0; d < N; d++)
            check(chain[d*32 +: 32] == 32'h00F00000, "R4", "all-skip frame", chain[d*32 +: 32], 32'h00F00000);
        check(!busy && cs_n && !sck, "R1", "quiet after transfers", {busy, cs_n, sck}, 3'b010);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule